// File: doc/BRIEF.md
# Pilot-tone tracking phase-locked loop

This block is a discrete-time phase-locked loop for a stereo broadcast receiver. It takes the demodulated baseband sample stream after a pilot bandpass prefilter and locks a local oscillator to the 19 kHz pilot tone. Each accepted sample goes through four stages. A multiplier phase detector mixes the sample with the local sine. A proportional-plus-integral loop filter turns that error into a frequency control word. A phase-accumulator oscillator adds the word to its phase. The phase word then drives the cosine generators.

From the same accumulator word, and with no extra tracking loop, the block also produces two phase-coherent references: cos(2θ) for the 38 kHz difference-channel subcarrier and cos(3θ) for the 57 kHz data subcarrier. The loop gains and the free-running frequency come in on static configuration inputs. A typical setting uses a 240 kHz sample rate, a free-running word of about 19/240·2^ACC_W, and gains chosen for a noise bandwidth near 10 Hz with damping 0.707. Wider bandwidths are available for faster pull-in.

Top module: `pilot_pll`

## Requirements
- R1: A synchronous active-high reset clears the phase accumulator, the integrator and the registered error, and holds `valid_o` low; afterwards `phase_o` reads 0.
- R2: On each clock with `vld_i` high the phase becomes phase + `fcw_base_i` + P + I' modulo 2^ACC_W. P = floor(e·`kp_mul_i`/2^`kp_sh_i`). I' is the saturated sum of the old integrator and floor(e·`ki_mul_i`/2^`ki_sh_i`). e is the error of that sample.
- R3: With `vld_i` low, the phase, the integrator, `err_o` and all references keep their values. `valid_o` is high exactly in the cycle after each accepted sample.
- R4: The cosine generator uses k, the top LUT_BITS bits of a phase, and H = 2^(LUT_BITS−1). Let u = (k + H/2) mod 2H and f = u mod H. The magnitude is floor(f·(H−f)·A / 2^(2·LUT_BITS−4)), with A = 2^(LO_W−1)−1. The output is this magnitude, negated when u ≥ H. `ref1_o` is this function of the phase.
- R5: `ref2_o` and `ref3_o` apply the same function to 2·phase and 3·phase modulo 2^ACC_W.
- R6: The local sine is the R4 function at index k − H/2 (mod 2H). For sample x and sine s, `err_o` shows −floor(x·s/2^PD_SHIFT) after the accepting edge.
- R7: The integrator saturates at 2^(INT_W−1)−1 and −2^(INT_W−1) instead of wrapping.
- R8: A 19 kHz pilot of amplitude 8192, sampled at 240 kHz with a 1 rad static phase offset, drives the 240-sample mean of `err_o` below 205 within 12000 samples. This holds with gains kp = 889/2^0 and ki = 19/2^3 and a free-running word of 340018244. The mean stays below 205 at the end of the run.
- R9: Under the same gains, a pilot 20 Hz above the free-running frequency also settles to a mean error below 205, because the integrator absorbs the frequency offset.
- R10: Once locked, `ref2_o` and `ref3_o` follow A·cos(2φ) and A·cos(3φ) of the input pilot phase φ to within 3500 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Sample strobe; one sample per high cycle |
| x_i | input | IN_W | Signed baseband sample |
| kp_mul_i | input | 16 | Signed proportional multiplier |
| kp_sh_i | input | 5 | Proportional right shift |
| ki_mul_i | input | 16 | Signed integral multiplier |
| ki_sh_i | input | 5 | Integral right shift |
| fcw_base_i | input | ACC_W | Free-running frequency word |
| phase_o | output | ACC_W | Tracked phase θ |
| err_o | output | IN_W+LO_W−PD_SHIFT | Registered phase-detector error (signed) |
| ref1_o | output | LO_W | cos(θ), signed |
| ref2_o | output | LO_W | cos(2θ), signed |
| ref3_o | output | LO_W | cos(3θ), signed |
| valid_o | output | 1 | Pulse one cycle after each accepted sample |

## Verification
The bench builds the block with LUT_BITS = 8, INT_W = 20, 16-bit samples and references, and a 32-bit accumulator. With LUT_BITS = 8 and a frequency word of one table step, the whole cosine function and both harmonic indexings can be swept in 256 samples, each compared with an arithmetic value. INT_W = 20 lets one large integral gain reach the clamp within a few samples, so a cycle-exact arithmetic model of the loop equation can follow the phase through saturation. The same width leaves enough headroom for the 20 Hz offset pull-in. Two closed-loop runs then measure settling of the windowed error and the coherence of the harmonic references.

// File: rtl/pilot_pll_pkg.sv
package pilot_pll_pkg;

    localparam int COEF_W  = 16;
    localparam int SHIFT_W = 5;

    typedef struct packed {
        logic signed [COEF_W-1:0] mul;
        logic [SHIFT_W-1:0]       shift;
    } gain_t;

    // Parabolic cosine of table index idx (tw index bits), peak amplitude amp.
    function automatic logic signed [31:0] wave_cos(input logic [31:0] idx,
                                                    input int unsigned tw,
                                                    input int unsigned amp);
        logic [31:0] half;
        logic [31:0] u;
        logic [31:0] f;
        logic [63:0] prod;
        logic [63:0] mag;
        logic [31:0] mag32;
        half  = 32'd1 << (tw - 1);
        u     = (idx + (half >> 1)) & ((half << 1) - 32'd1);
        f     = u & (half - 32'd1);
        prod  = {32'd0, f} * {32'd0, half - f};
        mag   = (prod * {32'd0, amp}) >> (2 * tw - 4);
        mag32 = mag[31:0];
        if ((u & half) != 32'd0)
            return -$signed(mag32);
        else
            return $signed(mag32);
    endfunction

endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det #(
    parameter int IN_W     = 16,
    parameter int LO_W     = 16,
    parameter int PD_SHIFT = 15
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               vld,
    input  logic signed [IN_W-1:0]             x,
    input  logic signed [LO_W-1:0]             lo_sin,
    output logic signed [IN_W+LO_W-PD_SHIFT-1:0] err_c,
    output logic signed [IN_W+LO_W-PD_SHIFT-1:0] err_q
);
    localparam int PW    = IN_W + LO_W;
    localparam int ERR_W = PW - PD_SHIFT;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        prod   = x * lo_sin;
        scaled = prod >>> PD_SHIFT;
        err_c  = -$signed(scaled[ERR_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= '0;
        else if (vld)
            err_q <= err_c;
    end

    // R3
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(err_q));

endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
    import pilot_pll_pkg::*;
#(
    parameter int ERR_W = 17,
    parameter int ACC_W = 32,
    parameter int INT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld,
    input  logic signed [ERR_W-1:0] err,
    input  gain_t                   kp,
    input  gain_t                   ki,
    input  logic [ACC_W-1:0]        base,
    output logic [ACC_W-1:0]        fcw
);
    localparam int TERM_W = ERR_W + COEF_W;
    localparam int IS_W   = ((INT_W > TERM_W) ? INT_W : TERM_W) + 1;
    localparam logic signed [IS_W-1:0] IMAX =
        $signed({{(IS_W - INT_W + 1){1'b0}}, {(INT_W - 1){1'b1}}});
    localparam logic signed [IS_W-1:0] IMIN = ~IMAX;

    logic signed [TERM_W-1:0] kp_prod, ki_prod;
    logic signed [TERM_W-1:0] kp_term, ki_term;
    logic signed [IS_W-1:0]   isum;
    logic signed [INT_W-1:0]  integ_q, integ_nx;

    always_comb begin
        kp_prod = err * $signed(kp.mul);
        ki_prod = err * $signed(ki.mul);
        kp_term = kp_prod >>> kp.shift;
        ki_term = ki_prod >>> ki.shift;
        isum    = IS_W'(integ_q) + IS_W'(ki_term);
        if (isum > IMAX)
            integ_nx = IMAX[INT_W-1:0];
        else if (isum < IMIN)
            integ_nx = IMIN[INT_W-1:0];
        else
            integ_nx = isum[INT_W-1:0];
        fcw = base + ACC_W'(kp_term) + ACC_W'(integ_nx);
    end

    always_ff @(posedge clk) begin
        if (rst)
            integ_q <= '0;
        else if (vld)
            integ_q <= integ_nx;
    end

    // R7
    integ_up_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && ki_term >= 0) |=> (integ_q >= $past(integ_q)));

    // R7
    integ_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && ki_term <= 0) |=> (integ_q <= $past(integ_q)));

endmodule

// File: rtl/dpll_nco.sv
module dpll_nco
    import pilot_pll_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int LUT_BITS = 10,
    parameter int LO_W     = 16,
    parameter int NHARM    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   vld,
    input  logic [ACC_W-1:0]       fcw,
    output logic [ACC_W-1:0]       phase_q,
    output logic signed [LO_W-1:0] lo_sin,
    output logic signed [LO_W-1:0] refs [NHARM]
);
    localparam int unsigned AMP = (2 ** (LO_W - 1)) - 1;
    localparam logic [LUT_BITS-1:0] QTR = LUT_BITS'(2 ** (LUT_BITS - 2));

    logic [LUT_BITS-1:0] sin_idx;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (vld)
            phase_q <= phase_q + fcw;
    end

    always_comb begin
        sin_idx = phase_q[ACC_W-1 -: LUT_BITS] - QTR;
        lo_sin  = LO_W'(wave_cos(32'(sin_idx), LUT_BITS, AMP));
    end

    for (genvar h = 0; h < NHARM; h++) begin : g_harm
        localparam logic [ACC_W-1:0] MULT = ACC_W'(h + 1);
        logic [ACC_W-1:0] hph;
        assign hph     = phase_q * MULT;
        assign refs[h] = LO_W'(wave_cos(32'(hph[ACC_W-1 -: LUT_BITS]), LUT_BITS, AMP));
    end

    // R1
    phase_reset_chk: assert property (@(posedge clk)
        rst |=> (phase_q == '0));

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(phase_q));

endmodule

// File: rtl/pilot_pll.sv
module pilot_pll
    import pilot_pll_pkg::*;
#(
    parameter int IN_W     = 16,
    parameter int LO_W     = 16,
    parameter int ACC_W    = 32,
    parameter int LUT_BITS = 10,
    parameter int INT_W    = 24,
    parameter int PD_SHIFT = 15
) (
    input  logic                                clk_i,
    input  logic                                rst_i,
    input  logic                                vld_i,
    input  logic signed [IN_W-1:0]              x_i,
    input  logic signed [COEF_W-1:0]            kp_mul_i,
    input  logic [SHIFT_W-1:0]                  kp_sh_i,
    input  logic signed [COEF_W-1:0]            ki_mul_i,
    input  logic [SHIFT_W-1:0]                  ki_sh_i,
    input  logic [ACC_W-1:0]                    fcw_base_i,
    output logic [ACC_W-1:0]                    phase_o,
    output logic signed [IN_W+LO_W-PD_SHIFT-1:0] err_o,
    output logic signed [LO_W-1:0]              ref1_o,
    output logic signed [LO_W-1:0]              ref2_o,
    output logic signed [LO_W-1:0]              ref3_o,
    output logic                                valid_o
);
    localparam int ERR_W = IN_W + LO_W - PD_SHIFT;
    localparam int NHARM = 3;

    gain_t                   kp_g, ki_g;
    logic signed [ERR_W-1:0] err_c;
    logic signed [LO_W-1:0]  lo_sin;
    logic signed [LO_W-1:0]  refs [NHARM];
    logic [ACC_W-1:0]        fcw;

    assign kp_g = '{mul: kp_mul_i, shift: kp_sh_i};
    assign ki_g = '{mul: ki_mul_i, shift: ki_sh_i};

    dpll_phase_det #(.IN_W(IN_W), .LO_W(LO_W), .PD_SHIFT(PD_SHIFT)) u_pd (
        .clk(clk_i), .rst(rst_i), .vld(vld_i), .x(x_i), .lo_sin(lo_sin),
        .err_c(err_c), .err_q(err_o));

    dpll_loop_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W), .INT_W(INT_W)) u_lf (
        .clk(clk_i), .rst(rst_i), .vld(vld_i), .err(err_c),
        .kp(kp_g), .ki(ki_g), .base(fcw_base_i), .fcw(fcw));

    dpll_nco #(.ACC_W(ACC_W), .LUT_BITS(LUT_BITS), .LO_W(LO_W), .NHARM(NHARM)) u_nco (
        .clk(clk_i), .rst(rst_i), .vld(vld_i), .fcw(fcw),
        .phase_q(phase_o), .lo_sin(lo_sin), .refs(refs));

    assign ref1_o = refs[0];
    assign ref2_o = refs[1];
    assign ref3_o = refs[2];

    always_ff @(posedge clk_i) begin
        if (rst_i)
            valid_o <= 1'b0;
        else
            valid_o <= vld_i;
    end

    // R3
    valid_track_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_i |=> valid_o);

    // R3
    valid_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> !valid_o);

endmodule

// File: tb/test_pilot_pll.sv
module test_pilot_pll;
    localparam int IN_W = 16, LO_W = 16, ACC_W = 32, LUT = 8, INT_W = 20, SH = 15;
    localparam int ERR_W = IN_W + LO_W - SH;
    localparam longint AMP = 32767;
    localparam longint IMAX = (64'sd1 <<< (INT_W - 1)) - 1;
    localparam longint IMIN = -(64'sd1 <<< (INT_W - 1));
    localparam real PI = 3.14159265358979;

    logic clk = 0, rst = 1, vld = 0;
    logic signed [IN_W-1:0]  x = '0;
    logic signed [15:0]      kp_mul = '0, ki_mul = '0;
    logic [4:0]              kp_sh = '0, ki_sh = '0;
    logic [ACC_W-1:0]        base = '0;
    logic [ACC_W-1:0]        phase;
    logic signed [ERR_W-1:0] err;
    logic signed [LO_W-1:0]  r1, r2, r3;
    logic                    vout;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pilot_pll #(.IN_W(IN_W), .LO_W(LO_W), .ACC_W(ACC_W), .LUT_BITS(LUT),
                .INT_W(INT_W), .PD_SHIFT(SH)) i_pilot_pll (
        .clk_i(clk), .rst_i(rst), .vld_i(vld), .x_i(x),
        .kp_mul_i(kp_mul), .kp_sh_i(kp_sh), .ki_mul_i(ki_mul), .ki_sh_i(ki_sh),
        .fcw_base_i(base), .phase_o(phase), .err_o(err),
        .ref1_o(r1), .ref2_o(r2), .ref3_o(r3), .valid_o(vout));

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint cosv(input longint k);
        longint h, u, f, m;
        h = 64'sd1 <<< (LUT - 1);
        u = (k + h / 2) & (2 * h - 1);
        f = u & (h - 1);
        m = (f * (h - f) * AMP) >>> (2 * LUT - 4);
        return (u >= h) ? -m : m;
    endfunction

    function automatic longint idx_of(input longint p);
        return (p >>> (ACC_W - LUT)) & ((64'sd1 <<< LUT) - 1);
    endfunction

    function automatic longint pd_err(input longint xv, input longint p);
        longint s;
        s = cosv(idx_of(p) - (64'sd1 <<< (LUT - 2)));
        return -((xv * s) >>> SH);
    endfunction

    task automatic do_reset();
        rst = 1; vld = 0; x = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic lock_run(input real f_hz, input string rq_lock, input string rq_ref);
        longint sum, d, xv;
        longint maxd2, maxd3;
        real ph, mean, last_mean;
        int settle_at;
        do_reset();
        kp_mul = 16'sd889; kp_sh = 5'd0; ki_mul = 16'sd19; ki_sh = 5'd3;
        base = 32'd340018244;
        sum = 0; settle_at = -1; last_mean = 0.0; maxd2 = 0; maxd3 = 0;
        for (int n = 0; n < 14400; n++) begin
            ph = 2.0 * PI * f_hz / 240000.0 * n + 1.0;
            if (n >= 14400 - 240) begin
                d = longint'($signed(r2)) - longint'($floor(32767.0 * $cos(2.0 * ph) + 0.5));
                if (d < 0) d = -d;
                if (d > maxd2) maxd2 = d;
                d = longint'($signed(r3)) - longint'($floor(32767.0 * $cos(3.0 * ph) + 0.5));
                if (d < 0) d = -d;
                if (d > maxd3) maxd3 = d;
            end
            xv = longint'($floor(8192.0 * $cos(ph) + 0.5));
            x = IN_W'(xv);
            vld = 1;
            @(posedge clk);
            @(negedge clk);
            sum += longint'($signed(err));
            if ((n + 1) % 240 == 0) begin
                mean = real'(sum) / 240.0;
                if (mean < 0.0) mean = -mean;
                if (mean < 205.0 && settle_at < 0) settle_at = n + 1;
                last_mean = mean;
                sum = 0;
            end
        end
        vld = 0;
        check({rq_lock, " settled within 12000 samples"},
              (settle_at > 0 && settle_at <= 12000) ? 1 : 0, 1);
        check({rq_lock, " final window mean below 205"}, (last_mean < 205.0) ? 1 : 0, 1);
        check({rq_ref, " cos(2θ) coherence max deviation within 3500"},
              (maxd2 <= 3500) ? 1 : 0, 1);
        check({rq_ref, " cos(3θ) coherence max deviation within 3500"},
              (maxd3 <= 3500) ? 1 : 0, 1);
    endtask

    initial begin : main
        longint xv, p, pm, integ, e, kpt, kit, isum;
        int clamps;

        do_reset();
        // R1: state after reset
        check("R1 phase after reset", longint'(phase), 0);
        check("R1 err after reset", longint'($signed(err)), 0);
        check("R1 valid_o after reset", longint'(vout), 0);
        check("R1 ref1 at zero phase", longint'($signed(r1)), AMP);

        // R4 R5 R6 R3: open-loop sweep of every table index
        kp_mul = '0; ki_mul = '0; kp_sh = '0; ki_sh = '0;
        base = 32'h0100_0000;
        for (int k = 0; k < 256; k++) begin
            check("R4 phase step", longint'(phase), longint'(k) <<< 24);
            check("R4 ref1 cosine", longint'($signed(r1)), cosv(k));
            check("R5 ref2 double phase", longint'($signed(r2)), cosv((2 * k) % 256));
            check("R5 ref3 triple phase", longint'($signed(r3)), cosv((3 * k) % 256));
            xv = ((longint'(k) * 7919) % 65536) - 32768;
            x = IN_W'(xv);
            vld = 1;
            @(posedge clk);
            @(negedge clk);
            vld = 0;
            check("R6 err from sample and sine", longint'($signed(err)), pd_err(xv, longint'(k) <<< 24));
            check("R3 valid_o after accepted sample", longint'(vout), 1);
            if (k % 16 == 5) begin
                p = longint'(phase);
                e = longint'($signed(err));
                x = IN_W'(12345);
                @(posedge clk);
                @(negedge clk);
                check("R3 phase held without strobe", longint'(phase), p);
                check("R3 err held without strobe", longint'($signed(err)), e);
                check("R3 valid_o low without strobe", longint'(vout), 0);
            end
        end

        // R8 R10: static phase offset; R9 R10: 20 Hz frequency offset
        lock_run(19000.0, "R8", "R10");
        lock_run(19020.0, "R9", "R10");

        // R1 R2 R7: cycle-exact loop equation with a clamping integrator
        do_reset();
        kp_mul = -16'sd300; kp_sh = 5'd2; ki_mul = 16'sd255; ki_sh = 5'd0;
        base = 32'h0312_3457;
        integ = 0; pm = 0; clamps = 0;
        for (int n = 0; n < 120; n++) begin
            p = longint'(phase);
            if (n == 0) check("R1 phase and integrator cleared before run", p, 0);
            else check((clamps > 0) ? "R7 phase with saturated integrator" : "R2 phase update",
                       p, pm);
            if (n % 7 == 3) begin
                x = IN_W'(4444);
                vld = 0;
                @(posedge clk);
                @(negedge clk);
                check("R3 phase held in closed loop", longint'(phase), p);
                pm = p;
            end else begin
                xv = ((longint'(n) * 5171) % 30000) - 15000;
                x = IN_W'(xv);
                vld = 1;
                e = pd_err(xv, p);
                kpt = (e * -300) >>> 2;
                kit = e * 255;
                isum = integ + kit;
                if (isum > IMAX) begin integ = IMAX; clamps++; end
                else if (isum < IMIN) begin integ = IMIN; clamps++; end
                else integ = isum;
                pm = (p + 64'sh0312_3457 + kpt + integ) & 64'hFFFF_FFFF;
                @(posedge clk);
                @(negedge clk);
                vld = 0;
                check("R6 err in closed loop", longint'($signed(err)), e);
            end
        end
        check("R7 final phase after saturation", longint'(phase), pm);
        check("R7 saturation reached during run", (clamps > 0) ? 1 : 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule